// File: doc/BRIEF.md
# Glitch-Free Clock Fanout Enable Controller

This block drives one reference clock onto a set of output lanes (five by default). It turns the lanes on and off without ever cutting a clock phase short. A select input picks the source. With select low, an external clock passes through unchanged. With select high, an oscillator-path clock passes through inverted. The output-enable request arrives asynchronously. Falling edges of the selected clock qualify it, so every change in what the lanes drive happens while the source is low.

Each lane has three outputs: a clock value, a drive-enable and a weak pull-low flag. A pad model or testbench uses them to tell the lane's four conditions apart. In the pulled-low condition the lane is only weakly tied to ground. In the driving condition it follows the source. In the forced-low condition it is actively driven low. In the high-impedance condition it does not drive at all. A disable is handled in two phases: the lane is held low first, and it releases to high impedance after the next rising edge of the source.

Top module: `clkgate_fanout`

## Requirements
- R1: All lanes always show identical clock, drive-enable and weak-pull values.
- R2: With selOsc = 0, a lane in the driving condition shows the level of extClk.
- R3: With selOsc = 1, a lane in the driving condition shows the inverse of oscClk, so a static low oscillator input gives a high output.
- R4: No high or low phase on a lane clock is shorter than half a period of the selected source.
- R5: Once oeReq is high while the lanes are not driving, the lanes show only the weak pull-low (weak-pull 1, drive-enable 0, clock 0) until the enable is qualified.
- R6: A rise of oeReq makes the lanes start driving at the second falling edge of the selected source after the rise. The clock is low at that point and follows the source afterwards.
- R7: A fall of oeReq keeps the lanes driving until the second falling edge of the source after the fall. From that edge on, the lanes are forced low (drive-enable 1, clock 0, weak-pull 0).
- R8: A forced-low lane leaves that condition at the next rising edge of the source. It becomes high impedance (drive-enable 0, weak-pull 0) if oeReq is low, or weakly pulled low if oeReq is high.
- R9: Drive-enable and weak-pull are never both high. Drive-enable is high only while driving or forced low.
- R10: Raising oeReq while the selected source is stopped leaves the lanes weakly pulled low at a static level, with no clock edges.
- R11: Asserting the active-low asynchronous reset puts every lane into high impedance at once and clears the qualification history. A request made after reset needs two full falling edges.
- R12: An oeReq level that does not persist across two consecutive falling edges of the source has no effect. The count restarts from the newest level, so a cancelled enable never drives and a cancelled disable never interrupts the clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| extClk | input | 1 | External reference clock, passed through unchanged when selected |
| oscClk | input | 1 | Oscillator-path clock, passed through inverted when selected |
| selOsc | input | 1 | Source select: 0 picks extClk, 1 picks the inverted oscClk |
| oeReq | input | 1 | Asynchronous output-enable request, active high |
| rstN | input | 1 | Asynchronous reset, active low |
| laneClk | output | LANES | Per-lane clock value |
| laneDrive | output | LANES | Per-lane active drive-enable |
| laneWeakPull | output | LANES | Per-lane weak pull-low flag |

## Verification
The timing properties count falling edges of the selected source. They assume that oeReq never changes in the same instant as a source edge, that selOsc changes only while the lanes are not driving, and that reset is asserted while the source is low. The stimulus meets all three assumptions. It updates oeReq, selOsc and rstN only at sample points midway between source edges. It switches the source only from the high-impedance condition, and it applies the mid-run reset just after a falling edge. Both source clocks advance in whole multiples of the bench period, so every phase width the pulse monitor measures is exact.

// File: rtl/clkgate_pkg.sv
`timescale 1ns/1ps
package clkgate_pkg;

  // Electrical condition presented by every lane.
  typedef enum logic [1:0] {
    LM_PULL      = 2'd0,
    LM_DRIVE     = 2'd1,
    LM_FORCE_LOW = 2'd2,
    LM_HIZ       = 2'd3
  } laneMode_e;

  // Strobes passed from the control to the lane datapath.
  typedef struct packed {
    logic passClk;   // lanes follow the selected source
    logic driveEn;   // lanes actively driven
    logic weakPull;  // lanes weakly tied low
  } laneStrobe_t;

endpackage

// File: rtl/clkgate_ctrl.sv
`timescale 1ns/1ps
module clkgate_ctrl
  import clkgate_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        srcClk,
  input  logic        rstN,
  input  logic        oeReq,
  output laneStrobe_t strobe
);

  localparam int CHAIN_LEN = SYNC_STAGES - 1;

  logic [CHAIN_LEN-1:0] chain;
  logic                 agree;
  logic                 qualEn;
  logic                 parked;
  laneMode_e            mode;

  // Falling-edge capture chain for the asynchronous request.
  for (genvar s = 0; s < CHAIN_LEN; s++) begin : g_sync
    logic stageIn;
    if (s == 0) begin : g_head
      assign stageIn = oeReq;
    end else begin : g_tail
      assign stageIn = chain[s-1];
    end
    always_ff @(negedge srcClk or negedge rstN) begin
      if (!rstN) chain[s] <= 1'b0;
      else       chain[s] <= stageIn;
    end
  end

  // The qualified enable moves only when every stage agrees with the
  // present request, so a level that does not persist is discarded.
  assign agree = (chain == {CHAIN_LEN{oeReq}});

  always_ff @(negedge srcClk or negedge rstN) begin
    if (!rstN)      qualEn <= 1'b0;
    else if (agree) qualEn <= oeReq;
  end

  // Rising-edge flag: set once the source has risen with the enable off,
  // which ends the forced-low phase.
  always_ff @(posedge srcClk or negedge rstN) begin
    if (!rstN) parked <= 1'b1;
    else       parked <= ~qualEn;
  end

  always_comb begin
    if (!rstN)       mode = LM_HIZ;
    else if (qualEn) mode = LM_DRIVE;
    else if (!parked) mode = LM_FORCE_LOW;
    else if (oeReq)  mode = LM_PULL;
    else             mode = LM_HIZ;
  end

  always_comb begin
    strobe.passClk  = (mode == LM_DRIVE);
    strobe.driveEn  = (mode == LM_DRIVE) || (mode == LM_FORCE_LOW);
    strobe.weakPull = (mode == LM_PULL);
  end

endmodule

// File: rtl/clkgate_lanes.sv
`timescale 1ns/1ps
module clkgate_lanes
  import clkgate_pkg::*;
#(
  parameter int LANES = 5
) (
  input  logic             extClk,
  input  logic             oscClk,
  input  logic             selOsc,
  input  laneStrobe_t      strobe,
  output logic             srcClk,
  output logic [LANES-1:0] laneClk,
  output logic [LANES-1:0] laneDrive,
  output logic [LANES-1:0] laneWeakPull
);

  // Source mux: the oscillator path is inverted on its way through.
  assign srcClk = selOsc ? ~oscClk : extClk;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneClk[l]      = srcClk & strobe.passClk;
    assign laneDrive[l]    = strobe.driveEn;
    assign laneWeakPull[l] = strobe.weakPull;
  end

endmodule

// File: rtl/clkgate_fanout.sv
`timescale 1ns/1ps
module clkgate_fanout
  import clkgate_pkg::*;
#(
  parameter int LANES       = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic             extClk,
  input  logic             oscClk,
  input  logic             selOsc,
  input  logic             oeReq,
  input  logic             rstN,
  output logic [LANES-1:0] laneClk,
  output logic [LANES-1:0] laneDrive,
  output logic [LANES-1:0] laneWeakPull
);

  logic        srcClk;
  laneStrobe_t strobe;

  clkgate_ctrl #(
    .SYNC_STAGES(SYNC_STAGES)
  ) u_ctrl (
    .srcClk (srcClk),
    .rstN   (rstN),
    .oeReq  (oeReq),
    .strobe (strobe)
  );

  clkgate_lanes #(
    .LANES(LANES)
  ) u_lanes (
    .extClk       (extClk),
    .oscClk       (oscClk),
    .selOsc       (selOsc),
    .strobe       (strobe),
    .srcClk       (srcClk),
    .laneClk      (laneClk),
    .laneDrive    (laneDrive),
    .laneWeakPull (laneWeakPull)
  );

endmodule

// File: rtl/clkgate_fanout_chk.sv
`timescale 1ns/1ps
module clkgate_fanout_chk #(
  parameter int LANES = 5
) (
  input logic             srcClk,
  input logic             rstN,
  input logic             oeReq,
  input logic [LANES-1:0] laneClk,
  input logic [LANES-1:0] laneDrive,
  input logic [LANES-1:0] laneWeakPull
);

  p_lanes_agree_r1: assert property (@(negedge srcClk) disable iff (!rstN)
    (laneClk == {LANES{laneClk[0]}}) &&
    (laneDrive == {LANES{laneDrive[0]}}) &&
    (laneWeakPull == {LANES{laneWeakPull[0]}}));

  p_flags_exclusive_r9: assert property (@(negedge srcClk) disable iff (!rstN)
    !(|(laneDrive & laneWeakPull)));

  // Just before a falling edge the source is high. A lane still driven
  // then must be passing the clock, so forced-low never outlives a rise.
  p_force_low_ends_r8: assert property (@(negedge srcClk) disable iff (!rstN)
    laneDrive[0] |-> laneClk[0]);

  // Driving starts only after the request was seen high at two falling edges.
  p_enable_latency_r6: assert property (@(negedge srcClk) disable iff (!rstN)
    $rose(laneDrive[0]) |-> ($past(oeReq, 2) && $past(oeReq)));

  // A request low at two falling edges has released the lanes by the next one.
  p_disable_done_r7: assert property (@(negedge srcClk) disable iff (!rstN)
    (!$past(oeReq, 2) && !$past(oeReq)) |-> !laneDrive[0]);

endmodule

bind clkgate_fanout clkgate_fanout_chk #(.LANES(LANES)) u_chk (
  .srcClk       (srcClk),
  .rstN         (rstN),
  .oeReq        (oeReq),
  .laneClk      (laneClk),
  .laneDrive    (laneDrive),
  .laneWeakPull (laneWeakPull)
);

// File: tb/test_clkgate_fanout.sv
`timescale 1ns/1ps
module test_clkgate_fanout;

  localparam int LANES = 5;
  localparam logic [1:0] M_PULL  = 2'd0;
  localparam logic [1:0] M_DRIVE = 2'd1;
  localparam logic [1:0] M_FLOW  = 2'd2;
  localparam logic [1:0] M_HIZ   = 2'd3;

  typedef struct packed {
    logic       sel;
    logic       oe;
    logic [2:0] falls;
    logic [1:0] rises;
    logic [1:0] expMode;
    logic [3:0] tag;
  } vec_t;

  localparam int NVEC = 25;
  localparam vec_t VECS [NVEC] = '{
    '{1'b0, 1'b1, 3'd0, 2'd0, M_PULL,  4'd5},
    '{1'b0, 1'b1, 3'd1, 2'd0, M_PULL,  4'd5},
    '{1'b0, 1'b1, 3'd1, 2'd0, M_DRIVE, 4'd6},
    '{1'b0, 1'b1, 3'd0, 2'd1, M_DRIVE, 4'd2},
    '{1'b0, 1'b0, 3'd1, 2'd0, M_DRIVE, 4'd7},
    '{1'b0, 1'b0, 3'd1, 2'd0, M_FLOW,  4'd7},
    '{1'b0, 1'b0, 3'd0, 2'd1, M_HIZ,   4'd8},
    '{1'b1, 1'b0, 3'd2, 2'd0, M_HIZ,   4'd8},
    '{1'b1, 1'b1, 3'd1, 2'd0, M_PULL,  4'd5},
    '{1'b1, 1'b1, 3'd1, 2'd0, M_DRIVE, 4'd6},
    '{1'b1, 1'b1, 3'd0, 2'd1, M_DRIVE, 4'd3},
    '{1'b1, 1'b0, 3'd2, 2'd0, M_FLOW,  4'd7},
    '{1'b1, 1'b1, 3'd0, 2'd0, M_FLOW,  4'd9},
    '{1'b1, 1'b1, 3'd0, 2'd1, M_PULL,  4'd8},
    '{1'b1, 1'b1, 3'd2, 2'd0, M_DRIVE, 4'd3},
    '{1'b1, 1'b0, 3'd2, 2'd1, M_HIZ,   4'd8},
    '{1'b0, 1'b0, 3'd2, 2'd0, M_HIZ,   4'd8},
    '{1'b0, 1'b1, 3'd1, 2'd0, M_PULL,  4'd5},
    '{1'b0, 1'b0, 3'd0, 2'd0, M_HIZ,   4'd12},
    '{1'b0, 1'b0, 3'd2, 2'd0, M_HIZ,   4'd12},
    '{1'b0, 1'b1, 3'd1, 2'd0, M_PULL,  4'd12},
    '{1'b0, 1'b1, 3'd1, 2'd0, M_DRIVE, 4'd6},
    '{1'b0, 1'b0, 3'd1, 2'd0, M_DRIVE, 4'd12},
    '{1'b0, 1'b1, 3'd1, 2'd0, M_DRIVE, 4'd12},
    '{1'b0, 1'b1, 3'd2, 2'd0, M_DRIVE, 4'd12}
  };

  logic tbClk = 1'b0;
  logic extClk = 1'b0, oscClk = 1'b0;
  logic selOsc = 1'b0, oeReq = 1'b0, rstN = 1'b0;
  logic extRun = 1'b1, oscRun = 1'b1;
  int   extCnt = 0, oscCnt = 0;
  logic [LANES-1:0] laneClk, laneDrive, laneWeakPull;

  int tests = 0, fails = 0;
  bit done = 0;

  clkgate_fanout #(.LANES(LANES)) i_clkgate_fanout (
    .extClk       (extClk),
    .oscClk       (oscClk),
    .selOsc       (selOsc),
    .oeReq        (oeReq),
    .rstN         (rstN),
    .laneClk      (laneClk),
    .laneDrive    (laneDrive),
    .laneWeakPull (laneWeakPull)
  );

  always #2 tbClk = ~tbClk;

  // Pulse-width monitor on lane 0 (R4).
  realtime lastEdge = 0.0;
  realtime minHalf = 8.0;
  bit      seenEdge = 0;
  int      edgeCount = 0, runtCount = 0;
  always @(laneClk[0]) begin
    if (seenEdge && ($realtime - lastEdge < minHalf)) runtCount++;
    if ($realtime > 0.0) begin
      seenEdge = 1;
      edgeCount++;
    end
    lastEdge = $realtime;
  end

  function automatic logic srcLvl();
    return selOsc ? ~oscClk : extClk;
  endfunction

  function automatic string tagName(input logic [3:0] n);
    case (n)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd12: return "R12";
      default: return "R?";
    endcase
  endfunction

  task automatic step();
    @(posedge tbClk);
    if (extRun) begin
      extCnt++;
      if (extCnt == 2) begin extCnt = 0; extClk = ~extClk; end
    end
    if (oscRun) begin
      oscCnt++;
      if (oscCnt == 3) begin oscCnt = 0; oscClk = ~oscClk; end
    end
    @(negedge tbClk);
  endtask

  task automatic waitFall();
    logic prev;
    do begin
      prev = srcLvl();
      step();
    end while (!(prev && !srcLvl()));
  endtask

  task automatic waitRise();
    logic prev;
    do begin
      prev = srcLvl();
      step();
    end while (!(!prev && srcLvl()));
  endtask

  task automatic checkMode(input string tag, input logic [1:0] expMode);
    logic expClk;
    logic [LANES-1:0] eC, eD, eP;
    expClk = (expMode == M_DRIVE) ? srcLvl() : 1'b0;
    eC = {LANES{expClk}};
    eD = {LANES{(expMode == M_DRIVE) || (expMode == M_FLOW)}};
    eP = {LANES{expMode == M_PULL}};
    tests++;
    if (laneClk !== eC || laneDrive !== eD || laneWeakPull !== eP) begin
      fails++;
      $display("FAIL %s (R1 lanes): clk=%b drive=%b pull=%b expected clk=%b drive=%b pull=%b",
               tag, laneClk, laneDrive, laneWeakPull, eC, eD, eP);
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int edgesBefore;
    // R11: reset state
    step(); step();
    #1 checkMode("R11", M_HIZ);
    rstN = 1'b1;
    step();

    for (int i = 0; i < NVEC; i++) begin
      selOsc  = VECS[i].sel;
      oeReq   = VECS[i].oe;
      minHalf = VECS[i].sel ? 12.0 : 8.0;
      for (int f = 0; f < int'(VECS[i].falls); f++) waitFall();
      for (int r = 0; r < int'(VECS[i].rises); r++) waitRise();
      #1 checkMode(tagName(VECS[i].tag), VECS[i].expMode);
    end

    // R11: reset while driving (source low, just after a falling edge)
    rstN = 1'b0;
    #1 checkMode("R11", M_HIZ);
    rstN = 1'b1;
    #1 checkMode("R11", M_PULL);
    waitFall();
    #1 checkMode("R11", M_PULL);
    waitFall();
    #1 checkMode("R6", M_DRIVE);

    // R10: request raised with the source stopped
    oeReq = 1'b0;
    waitFall(); waitFall(); waitRise();
    #1 checkMode("R8", M_HIZ);
    waitFall();
    extRun = 1'b0;
    oeReq = 1'b1;
    edgesBefore = edgeCount;
    for (int k = 0; k < 40; k++) step();
    #1 checkMode("R10", M_PULL);
    tests++;
    if (edgeCount != edgesBefore) begin
      fails++;
      $display("FAIL R10: lane edges=%0d expected %0d", edgeCount, edgesBefore);
    end

    // R4: no shortened phase seen over the whole run
    tests++;
    if (runtCount != 0 || edgeCount < 10) begin
      fails++;
      $display("FAIL R4: runts=%0d edges=%0d expected runts=0 edges>=10", runtCount, edgeCount);
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule